// File: doc/BRIEF.md
# Floating-Point Immediate Load Unit

This execution block serves a scalar instruction that writes a 64-bit floating-point register from a 32-bit immediate. A 2-bit mode field picks one of three treatments of the immediate. The first widens it as a single-precision value into the equivalent double. The second splices it under the current register contents, which are first narrowed back to single-precision bit format. The third zero-extends it as a raw bit pattern. With the second mode, two instructions issued one after the other can build any 64-bit double: the first deposits the high word through widening, and the second narrows it back and appends the low word.

The decoder offers an instruction with `in_valid`, together with the mode, the immediate and the target register's current value. The block accepts it when `in_ready` is high. One cycle later it presents the 64-bit result on `res_data`, and `res_valid` acts as the register write-enable. The write port acknowledges with `res_ready`. While `res_valid` is high and `res_ready` is low, the result is held unchanged and `in_ready` is low, so no new instruction enters. An offer made in that state is simply not taken. The reserved mode produces a one-cycle `res_illegal` pulse and no write. Narrowing truncates; the block has no rounding.

Top module: `fimm_load_unit`

## Requirements
- R1: During and directly after reset, `res_valid` and `res_illegal` are 0 and `in_ready` is 1.
- R2: Mode 2'b00 widens a zero, normal or infinite single-precision immediate to a double. The sign is kept, a nonzero finite exponent is re-biased by +896, exponent 255 becomes 2047, and the 23-bit fraction occupies result bits 51:29 with zeros below.
- R3: In mode 2'b00 a NaN immediate widens to a double NaN whose bits 51:29 equal the 23 input fraction bits, so the quiet bit and the payload are preserved.
- R4: In mode 2'b00 a denormal immediate is normalized. With the leading one at fraction bit p, the double exponent is p+874 and the fraction bits below p are left-aligned into bits 51:29.
- R5: Mode 2'b01 writes the narrowed current register value to result bits 63:32 and the immediate to bits 31:0. Mode 00 with 0x12345678 followed by mode 01 with 0x9abcdef0 on the same register gives 0x123456789abcdef0.
- R6: For a double exponent E from 897 to 2047, or for a zero input, narrowing takes bits 63, 62 and 58:29. For E from 874 to 896 it yields a single denormal: the mantissa {1, bits 51:29} is shifted right by 897-E and truncated. Widening then narrowing therefore returns the original 32 bits for every class.
- R7: Mode 2'b10 writes 32 zero bits above the immediate.
- R8: Mode 2'b11 is reserved. One cycle after acceptance `res_illegal` is 1 for exactly one cycle, `res_valid` stays 0, and `res_data` keeps its old value.
- R9: A result appears with `res_valid` high in the cycle after `in_valid` and `in_ready` are both high. Without an accepted strobe, neither `res_valid` nor `res_illegal` rises.
- R10: While `res_valid` is 1 and `res_ready` is 0, `in_ready` is 0 and `res_data` and `res_valid` hold. An offered instruction is not taken until the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction this cycle |
| in_mode | input | 2 | Immediate treatment: 00 widen, 01 splice, 10 zero-extend, 11 reserved |
| in_imm | input | 32 | 32-bit immediate |
| in_cur | input | 64 | Current contents of the target register |
| res_valid | output | 1 | Result valid; register write-enable |
| res_ready | input | 1 | Write port accepts the result |
| res_data | output | 64 | Value to write to the target register |
| res_illegal | output | 1 | One-cycle pulse for an accepted reserved mode |

## Verification
The bench goes after the widening corner cases: signed zeros, the largest normal, both infinities, quiet and signalling NaNs with payloads, and denormals whose leading one is at the bottom or the top of the fraction. A converter that forgot to normalize would write a double denormal or a wrong exponent, and one that dropped the payload would turn a signalling NaN into an infinity. Every vector is also narrowed back through the splice mode. A narrower without the denormal path would return a large garbage exponent for the denormal inputs instead of the original bits. Further directed cases cover the two-instruction sequence that builds a full double, the reserved mode, which must flag the instruction without writing, and a stalled write port, which a careless design would overwrite or let drop its result.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam int SP_W    = 32;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = SP_W - SP_EXP - 1;
  localparam int DP_W    = 64;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = DP_W - DP_EXP - 1;
  localparam int SP_BIAS = (1 << (SP_EXP - 1)) - 1;
  localparam int DP_BIAS = (1 << (DP_EXP - 1)) - 1;
  localparam int EXP_ADJ = DP_BIAS - SP_BIAS;
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_WIDEN  = 2'b00,
    MODE_SPLICE = 2'b01,
    MODE_ZEXT   = 2'b10,
    MODE_RSVD   = 2'b11
  } fimm_mode_e;
endpackage

// File: rtl/fimm_widen.sv
module fimm_widen
  import fimm_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  output logic [DP_W-1:0] dp_o
);
  localparam int PAD = DP_FRAC - SP_FRAC;
  localparam int LZW = $clog2(SP_FRAC + 1);

  logic               sgn;
  logic [SP_EXP-1:0]  exp_s;
  logic [SP_FRAC-1:0] frc_s;
  logic [LZW-1:0]     lead;
  logic [LZW-1:0]     shamt;
  logic [SP_FRAC-1:0] frc_n;
  logic [DP_EXP-1:0]  exp_den;
  logic [DP_EXP-1:0]  exp_nrm;

  assign {sgn, exp_s, frc_s} = sp_i;

  // highest set fraction bit; ascending loop, last hit wins
  always_comb begin
    lead = '0;
    for (int i = 0; i < SP_FRAC; i++)
      if (frc_s[i]) lead = LZW'(i);
  end

  assign shamt   = LZW'(SP_FRAC) - lead;
  assign frc_n   = frc_s << shamt;
  assign exp_den = DP_EXP'(EXP_ADJ + 1) - DP_EXP'(shamt);
  assign exp_nrm = DP_EXP'(exp_s) + DP_EXP'(EXP_ADJ);

  always_comb begin
    if (exp_s == '0 && frc_s == '0)
      dp_o = {sgn, {(DP_W-1){1'b0}}};
    else if (exp_s == '0)
      dp_o = {sgn, exp_den, frc_n, {PAD{1'b0}}};
    else if (exp_s == '1)
      dp_o = {sgn, {DP_EXP{1'b1}}, frc_s, {PAD{1'b0}}};
    else
      dp_o = {sgn, exp_nrm, frc_s, {PAD{1'b0}}};
  end
endmodule

// File: rtl/fimm_narrow.sv
module fimm_narrow
  import fimm_pkg::*;
(
  input  logic [DP_W-1:0] dp_i,
  output logic [SP_W-1:0] sp_o
);
  localparam int DEN_LO = EXP_ADJ + 1 - SP_FRAC;
  localparam int DEN_HI = EXP_ADJ;

  logic               sgn;
  logic [DP_EXP-1:0]  exp_d;
  logic [DP_FRAC-1:0] frc_d;
  logic [SP_FRAC:0]   mant;
  logic [SP_FRAC:0]   mant_sh;
  logic               in_den;

  assign {sgn, exp_d, frc_d} = dp_i;
  assign mant   = {1'b1, frc_d[DP_FRAC-1 -: SP_FRAC]};
  assign in_den = (int'(exp_d) >= DEN_LO) && (int'(exp_d) <= DEN_HI);

  always_comb begin
    mant_sh = mant >> (DEN_HI + 1 - int'(exp_d));
    if (in_den)
      sp_o = {sgn, {SP_EXP{1'b0}}, mant_sh[SP_FRAC-1:0]};
    else
      sp_o = {sgn, exp_d[DP_EXP-1], exp_d[SP_EXP-2:0],
              frc_d[DP_FRAC-1 -: SP_FRAC]};
  end
endmodule

// File: rtl/fimm_select.sv
module fimm_select
  import fimm_pkg::*;
(
  input  fimm_mode_e      mode_i,
  input  logic [SP_W-1:0] imm_i,
  input  logic [DP_W-1:0] wide_i,
  input  logic [SP_W-1:0] narrow_i,
  output logic [DP_W-1:0] data_o,
  output logic            legal_o
);
  localparam int HI_W = DP_W - SP_W;

  always_comb begin
    legal_o = 1'b1;
    unique case (mode_i)
      MODE_WIDEN:  data_o = wide_i;
      MODE_SPLICE: data_o = {narrow_i, imm_i};
      MODE_ZEXT:   data_o = {{HI_W{1'b0}}, imm_i};
      default: begin
        data_o  = '0;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fimm_load_unit.sv
module fimm_load_unit
  import fimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [SP_W-1:0]   in_imm,
  input  logic [DP_W-1:0]   in_cur,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DP_W-1:0]   res_data,
  output logic              res_illegal
);
  logic [DP_W-1:0] wide;
  logic [SP_W-1:0] narrow;
  logic [DP_W-1:0] nxt_data;
  logic            legal;
  logic            accept;

  fimm_widen  u_widen  (.sp_i(in_imm), .dp_o(wide));
  fimm_narrow u_narrow (.dp_i(in_cur), .sp_o(narrow));
  fimm_select u_select (
    .mode_i  (fimm_mode_e'(in_mode)),
    .imm_i   (in_imm),
    .wide_i  (wide),
    .narrow_i(narrow),
    .data_o  (nxt_data),
    .legal_o (legal)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_data    <= '0;
    end else if (accept) begin
      res_valid   <= legal;
      res_illegal <= !legal;
      if (legal) res_data <= nxt_data;
    end else begin
      if (res_ready) res_valid <= 1'b0;
      res_illegal <= 1'b0;
    end
  end

  AST_INF_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == 2'b00 && in_imm[30:23] == 8'hFF
      |=> res_data[62:52] == 11'h7FF) else $error("inf exp"); // R2
  AST_SPLICE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == 2'b01 |=> res_data[31:0] == $past(in_imm)) else $error("splice"); // R5
  AST_ZEXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == 2'b10 |=> res_data[63:32] == '0) else $error("zext"); // R7
  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == 2'b11 |=> res_illegal && !res_valid && $stable(res_data)) else $error("rsvd"); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !res_illegal && !$rose(res_valid)) else $error("spurious"); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data)) else $error("stall"); // R10
endmodule

// File: tb/fimm_load_unit_bench.sv
module fimm_load_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'b00;
  logic [31:0] in_imm = '0;
  logic [63:0] in_cur = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic        res_illegal;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  fimm_load_unit u_fimm_load_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_imm(in_imm), .in_cur(in_cur),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_illegal(res_illegal)
  );

  // {single input, expected double}
  localparam logic [95:0] VEC [14] = '{
    {32'h00000000, 64'h0000000000000000},
    {32'h80000000, 64'h8000000000000000},
    {32'h3F800000, 64'h3FF0000000000000},
    {32'hC0000000, 64'hC000000000000000},
    {32'h12345678, 64'h3A468ACF00000000},
    {32'h7F7FFFFF, 64'h47EFFFFFE0000000},
    {32'h7F800000, 64'h7FF0000000000000},
    {32'hFF800000, 64'hFFF0000000000000},
    {32'h7FC00000, 64'h7FF8000000000000},
    {32'h7F800001, 64'h7FF0000020000000},
    {32'h00000001, 64'h36A0000000000000},
    {32'h00400000, 64'h3800000000000000},
    {32'h00600000, 64'h3808000000000000},
    {32'h807FFFFF, 64'hB80FFFFFC0000000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [31:0] imm, input logic [63:0] cur);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_imm = imm; in_cur = cur;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] reg_m;
    repeat (2) @(negedge clk);
    check("R1 valid", {63'd0, res_valid}, 64'd0);
    check("R1 illegal", {63'd0, res_illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", {63'd0, in_ready}, 64'd1);
    check("R1 valid after", {63'd0, res_valid}, 64'd0);

    // table walk: widen (R2 R3 R4), then narrow back via splice (R6)
    for (int i = 0; i < 14; i++) begin
      issue(2'b00, VEC[i][95:64], 64'hDEAD_BEEF_0000_0000);
      check("R2/R3/R4 widen", res_data, VEC[i][63:0]);
      check("R9 valid", {63'd0, res_valid}, 64'd1);
      issue(2'b01, 32'hA5A5A5A5, res_data);
      check("R6 round trip", res_data, {VEC[i][95:64], 32'hA5A5A5A5});
    end

    // R5 two-step build
    issue(2'b00, 32'h12345678, 64'd0);
    reg_m = res_data;
    issue(2'b01, 32'h9abcdef0, reg_m);
    check("R5 build", res_data, 64'h123456789abcdef0);

    // R6 narrowing of directly supplied doubles
    issue(2'b01, 32'h0, 64'h3FF0000000000000);
    check("R6 one", res_data, 64'h3F80000000000000);
    issue(2'b01, 32'h0, 64'h3800000000000000);
    check("R6 denorm", res_data, 64'h0040000000000000);

    // R7 zero-extend
    issue(2'b10, 32'h12345678, 64'hFFFFFFFFFFFFFFFF);
    check("R7 zext", res_data, 64'h0000000012345678);

    // R8 reserved mode
    issue(2'b11, 32'h55555555, 64'd0);
    check("R8 illegal", {63'd0, res_illegal}, 64'd1);
    check("R8 no write", {63'd0, res_valid}, 64'd0);
    check("R8 data kept", res_data, 64'h0000000012345678);
    @(negedge clk);
    check("R8 pulse ends", {63'd0, res_illegal}, 64'd0);

    // R9 no strobe, no result
    in_mode = 2'b10; in_imm = 32'h77777777;
    repeat (2) @(negedge clk);
    check("R9 idle", {63'd0, res_valid}, 64'd0);
    check("R9 idle data", res_data, 64'h0000000012345678);

    // R10 back-pressure
    res_ready = 1'b0;
    issue(2'b10, 32'h11111111, 64'd0);
    check("R10 first", res_data, 64'h0000000011111111);
    in_valid = 1'b1; in_mode = 2'b10; in_imm = 32'h22222222;
    #1;
    check("R10 not ready", {63'd0, in_ready}, 64'd0);
    repeat (2) @(negedge clk);
    check("R10 held", res_data, 64'h0000000011111111);
    check("R10 valid held", {63'd0, res_valid}, 64'd1);
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 taken after stall", res_data, 64'h0000000022222222);
    @(negedge clk);
    check("R10 drained", {63'd0, res_valid}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule